// File: doc/BRIEF.md
# Receive Buffer Ring Fetcher

This block keeps the receive side of a network controller supplied with buffer space. The host software places buffer descriptors in a circular area of memory. Each descriptor gives the base address of a receive buffer and its size in 16-bit words. On request, the fetcher reads the descriptor that the read pointer names and loads the current buffer address and the remaining word count from it. It then moves the read pointer past that descriptor, wrapping back to the start of the area when it reaches the end.

When the moved pointer lands on the host's write pointer, the ring has no more buffers. The fetcher raises an exhaustion flag, and the receive path refuses packets until the host clears the flag. Clearing the flag also starts a fetch.

A fetch is started by a command pulse, by clearing the exhaustion flag while it is set, or by the packet path. After each stored packet the remaining word count drops. If it falls below a programmable threshold, the packet is marked as the last one in that buffer and the next descriptor is fetched.

Top module: `rx_ring_fetcher`

## Requirements
- R1: A fetch reads four 16-bit fields in this order: buffer base low, buffer base high, word count low, word count high. Field k is read at byte address {upper_addr, rd_ptr} + k*2 when cfg_wide=0, and + k*4 when cfg_wide=1. mem_req stays high with an unchanged mem_addr until mem_ack is seen, and each field is taken from mem_rdata in the cycle of its mem_ack.
- R2: After a fetch, buf_addr equals {base high, base low} and buf_words equals {count high, count low}.
- R3: At the end of a fetch, rd_ptr advances by 8 bytes (cfg_wide=0) or 16 bytes (cfg_wide=1). If the advanced value equals ring_end, rd_ptr takes ring_start instead.
- R4: If rd_ptr equals ring_wr after the advance and wrap, exhausted is set. It stays set until the host clears it.
- R5: cmd_pending goes high one cycle after a cmd_fetch pulse and goes low when a fetch completes.
- R6: An exh_clear pulse while exhausted is set clears exhausted and starts a fetch. While exhausted is clear, the pulse starts no fetch and leaves rd_ptr unchanged.
- R7: An accepted pkt_done lowers buf_words by (pkt_bytes+4)/2. It sets last_pkt exactly when the new count is below eob_words, and in that case it also starts a fetch.
- R8: rx_ready equals rx_enable and not exhausted. A pkt_done while rx_ready is low changes neither buf_words nor last_pkt.
- R9: A fetch request that arrives during a fetch is held. A second fetch then runs as soon as the first one completes.
- R10: A host write of rd_ptr drops bit 0. Bit 0 of ring_start, ring_end and ring_wr is ignored in every comparison.
- R11: After reset the following outputs are all zero: rd_ptr, buf_addr, buf_words, exhausted, cmd_pending, last_pkt, busy and mem_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wide | input | 1 | 1: 32-bit descriptor layout; 0: 16-bit layout |
| upper_addr | input | 16 | Upper half of every descriptor address |
| ring_start | input | 16 | Ring start pointer |
| ring_end | input | 16 | Ring end pointer |
| ring_wr | input | 16 | Host write pointer |
| rp_wr_en | input | 1 | Host write of the read pointer |
| rp_wr_data | input | 16 | Value for the read pointer |
| rd_ptr | output | 16 | Current read pointer |
| cmd_fetch | input | 1 | Fetch command pulse |
| cmd_pending | output | 1 | Command bit, cleared when a fetch completes |
| exh_clear | input | 1 | Host clear of the exhaustion flag |
| exhausted | output | 1 | Ring exhausted flag |
| rx_enable | input | 1 | Receiver enabled |
| rx_ready | output | 1 | Packet reception allowed |
| pkt_done | input | 1 | A packet has been stored |
| pkt_bytes | input | 16 | Byte count of that packet without CRC |
| eob_words | input | 16 | Low-space threshold in words |
| last_pkt | output | 1 | Last packet fits in the current buffer |
| buf_addr | output | 32 | Current buffer address |
| buf_words | output | 32 | Remaining buffer words |
| busy | output | 1 | Fetch in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_ack | input | 1 | Read data valid, request accepted |
| mem_rdata | input | 16 | Read data |

## Verification
The hardest case to reach is a second request that lands in the middle of a fetch. It must be held and then served without any field or pointer step being lost. The stimulus reaches it by sending a second command while the memory responder is still stalling the first fetch with randomly withheld acknowledges. The low-space refetch is also hard to reach, because it needs a word count that is known and small. The responder's memory function therefore returns small values for the word-count-high field, which lets the bench pick a threshold just above the count a packet leaves behind.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int PTR_W   = 16;
  localparam int ADDR_W  = 2 * PTR_W;
  localparam int DATA_W  = 16;
  localparam int CNT_W   = 2 * DATA_W;
  localparam int NFIELDS = 4;
  localparam int IDX_W   = $clog2(NFIELDS);
  localparam logic [PTR_W-1:0] ALIGN_MASK = {{(PTR_W-1){1'b1}}, 1'b0};

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_STEP} seq_state_t;

  // byte address of descriptor field idx
  function automatic logic [ADDR_W-1:0] field_addr(input logic [PTR_W-1:0] up,
                                                   input logic [PTR_W-1:0] rp,
                                                   input logic [IDX_W-1:0] idx,
                                                   input logic wide);
    logic [ADDR_W-1:0] off;
    off = wide ? ADDR_W'({idx, 2'b00}) : ADDR_W'({idx, 1'b0});
    return {up, rp} + off;
  endfunction

  // pointer after one descriptor, with wrap
  function automatic logic [PTR_W-1:0] advance_ptr(input logic [PTR_W-1:0] rp,
                                                   input logic [PTR_W-1:0] st,
                                                   input logic [PTR_W-1:0] en,
                                                   input logic wide);
    logic [PTR_W-1:0] nxt;
    nxt = rp + (wide ? PTR_W'(16) : PTR_W'(8));
    return ((nxt & ALIGN_MASK) == (en & ALIGN_MASK)) ? (st & ALIGN_MASK) : (nxt & ALIGN_MASK);
  endfunction

  // remaining words after a packet plus its CRC
  function automatic logic [CNT_W-1:0] words_after_pkt(input logic [CNT_W-1:0] w,
                                                       input logic [DATA_W-1:0] bytes);
    logic [CNT_W-1:0] used;
    used = (CNT_W'(bytes) + CNT_W'(4)) >> 1;
    return w - used;
  endfunction
endpackage

// File: rtl/rrf_ptr_unit.sv
module rrf_ptr_unit
  import rrf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide,
  input  logic [PTR_W-1:0] start_p,
  input  logic [PTR_W-1:0] end_p,
  input  logic [PTR_W-1:0] wr_p,
  input  logic             host_we,
  input  logic [PTR_W-1:0] host_data,
  input  logic             adv,
  output logic [PTR_W-1:0] rp,
  output logic             hit
);
  logic [PTR_W-1:0] rp_next;

  always_comb begin
    rp_next = advance_ptr(rp, start_p, end_p, wide);
    hit     = (rp_next == (wr_p & ALIGN_MASK));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rp <= '0;
    else if (adv)     rp <= rp_next;
    else if (host_we) rp <= host_data & ALIGN_MASK;
  end

  p_rp_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n) rp[0] == 1'b0);
  p_rp_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rp) |-> $past(adv || host_we));
endmodule

// File: rtl/rrf_seq.sv
module rrf_seq
  import rrf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic [PTR_W-1:0]  upper,
  input  logic [PTR_W-1:0]  rp,
  input  logic              go,
  input  logic              cmd_set,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NFIELDS-1:0] ld_en,
  output logic              adv,
  output logic              busy,
  output logic              cmd_bit
);
  seq_state_t       state;
  logic [IDX_W-1:0] idx;
  logic             pending;
  logic             last_field;

  always_comb begin
    mem_req    = (state == ST_READ);
    mem_addr   = field_addr(upper, rp, idx, wide);
    last_field = (idx == IDX_W'(NFIELDS - 1));
    adv        = (state == ST_STEP);
    busy       = (state != ST_IDLE);
    ld_en      = (mem_req && mem_ack) ? (NFIELDS'(1) << idx) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx     <= '0;
      pending <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (go) begin
          state <= ST_READ;
          idx   <= '0;
        end
        ST_READ: begin
          if (go) pending <= 1'b1;
          if (mem_ack) begin
            if (last_field) state <= ST_STEP;
            else            idx   <= idx + 1'b1;
          end
        end
        ST_STEP: begin
          if (go || pending) begin
            state   <= ST_READ;
            idx     <= '0;
            pending <= 1'b0;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cmd_bit <= 1'b0;
    else if (cmd_set)           cmd_bit <= 1'b1;
    else if (state == ST_STEP)  cmd_bit <= 1'b0;
  end

  p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  p_cmd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_bit) |-> $past(state == ST_STEP));
  p_held_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && adv) |=> mem_req);
endmodule

// File: rtl/rrf_space.sv
module rrf_space
  import rrf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NFIELDS-1:0] ld_en,
  input  logic [DATA_W-1:0]  rdata,
  input  logic               pkt_ok,
  input  logic [DATA_W-1:0]  pkt_bytes,
  input  logic [DATA_W-1:0]  eob,
  output logic [ADDR_W-1:0]  buf_addr,
  output logic [CNT_W-1:0]   buf_words,
  output logic               last_pkt,
  output logic               low_req
);
  logic [CNT_W-1:0] words_next;
  logic             below;

  always_comb begin
    words_next = words_after_pkt(buf_words, pkt_bytes);
    below      = (words_next < CNT_W'(eob));
    low_req    = pkt_ok && below;
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        buf_addr[h*DATA_W +: DATA_W] <= '0;
      else if (ld_en[h]) buf_addr[h*DATA_W +: DATA_W] <= rdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            buf_words[h*DATA_W +: DATA_W] <= '0;
      else if (ld_en[2 + h]) buf_words[h*DATA_W +: DATA_W] <= rdata;
      else if (pkt_ok)       buf_words[h*DATA_W +: DATA_W] <= words_next[h*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_pkt <= 1'b0;
    else if (pkt_ok) last_pkt <= below;
  end

  p_last_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(last_pkt) |-> $past(pkt_ok));
endmodule

// File: rtl/rx_ring_fetcher.sv
module rx_ring_fetcher
  import rrf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wide,
  input  logic [15:0] upper_addr,
  input  logic [15:0] ring_start,
  input  logic [15:0] ring_end,
  input  logic [15:0] ring_wr,
  input  logic        rp_wr_en,
  input  logic [15:0] rp_wr_data,
  output logic [15:0] rd_ptr,
  input  logic        cmd_fetch,
  output logic        cmd_pending,
  input  logic        exh_clear,
  output logic        exhausted,
  input  logic        rx_enable,
  output logic        rx_ready,
  input  logic        pkt_done,
  input  logic [15:0] pkt_bytes,
  input  logic [15:0] eob_words,
  output logic        last_pkt,
  output logic [31:0] buf_addr,
  output logic [31:0] buf_words,
  output logic        busy,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [15:0] mem_rdata
);
  logic               adv;
  logic               hit;
  logic               low_req;
  logic               go;
  logic               pkt_ok;
  logic [NFIELDS-1:0] ld_en;

  always_comb begin
    rx_ready = rx_enable && !exhausted;
    pkt_ok   = pkt_done && rx_ready;
    go       = cmd_fetch || (exh_clear && exhausted) || low_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          exhausted <= 1'b0;
    else if (adv && hit) exhausted <= 1'b1;
    else if (exh_clear)  exhausted <= 1'b0;
  end

  rrf_ptr_unit u_ptr (
    .clk(clk), .rst_n(rst_n), .wide(cfg_wide),
    .start_p(ring_start), .end_p(ring_end), .wr_p(ring_wr),
    .host_we(rp_wr_en), .host_data(rp_wr_data),
    .adv(adv), .rp(rd_ptr), .hit(hit)
  );

  rrf_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wide(cfg_wide), .upper(upper_addr), .rp(rd_ptr),
    .go(go), .cmd_set(cmd_fetch), .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_addr(mem_addr), .ld_en(ld_en),
    .adv(adv), .busy(busy), .cmd_bit(cmd_pending)
  );

  rrf_space u_space (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .rdata(mem_rdata),
    .pkt_ok(pkt_ok), .pkt_bytes(pkt_bytes), .eob(eob_words),
    .buf_addr(buf_addr), .buf_words(buf_words),
    .last_pkt(last_pkt), .low_req(low_req)
  );

  p_exh_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exhausted) |-> $past(adv));
  p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !rx_ready && !busy) |=> $stable(buf_words));
endmodule

// File: tb/rx_ring_fetcher_test.sv
module rx_ring_fetcher_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cfg_wide, rp_wr_en, cmd_fetch, exh_clear, rx_enable, pkt_done;
  logic [15:0] upper_addr, ring_start, ring_end, ring_wr, rp_wr_data, pkt_bytes, eob_words;
  logic [15:0] rd_ptr, mem_rdata;
  logic        cmd_pending, exhausted, rx_ready, last_pkt, busy, mem_req, mem_ack;
  logic [31:0] buf_addr, buf_words, mem_addr;

  rx_ring_fetcher uut (.*);

  int vecs = 0, errs = 0;
  logic [15:0] m_rp;
  logic [31:0] m_addr, m_words;
  logic        m_exh;
  int          fc = 0;

  function automatic logic [15:0] memw(input logic [31:0] a);
    if (a[3:0] == 4'h6 || a[3:0] == 4'hE || a[3:0] == 4'hC) return {12'h000, a[7:4]};
    return (a[15:0] * 16'h9E37) ^ a[31:16] ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] step_m(input logic [15:0] rp, input logic w);
    logic [15:0] s;
    s = rp + (w ? 16'd16 : 16'd8);
    if (s[15:1] == ring_end[15:1]) s = {ring_start[15:1], 1'b0};
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_fetch();
    logic [31:0] d;
    int s;
    d = {upper_addr, m_rp};
    s = cfg_wide ? 4 : 2;
    m_addr  = {memw(d + 32'(s)), memw(d)};
    m_words = {memw(d + 32'(3*s)), memw(d + 32'(2*s))};
    m_rp = step_m(m_rp, cfg_wide);
    if (m_rp[15:1] == ring_wr[15:1]) m_exh = 1'b1;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic pulse_cmd();
    cmd_fetch = 1'b1; @(negedge clk); cmd_fetch = 1'b0;
  endtask

  task automatic host_rp(input logic [15:0] v);
    rp_wr_en = 1'b1; rp_wr_data = v; @(negedge clk); rp_wr_en = 1'b0;
    m_rp = {v[15:1], 1'b0};
  endtask

  task automatic check_all(input string tag);
    chk({tag, " rd_ptr"}, 32'(rd_ptr), 32'(m_rp));
    chk({tag, " buf_addr"}, buf_addr, m_addr);
    chk({tag, " buf_words"}, buf_words, m_words);
    chk({tag, " exhausted"}, 32'(exhausted), 32'(m_exh));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  // memory responder with random stalls; R1 field address check
  initial begin
    mem_ack = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req && ($urandom % 3 != 0)) begin
        chk("R1 field address", mem_addr,
            {upper_addr, rd_ptr} + 32'(fc * (cfg_wide ? 4 : 2)));
        fc = (fc + 1) % 4;
        mem_ack = 1'b1; mem_rdata = memw(mem_addr);
      end else begin
        mem_ack = 1'b0; mem_rdata = '0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] nxt;
    logic [15:0] keep;
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; cfg_wide = 0; rp_wr_en = 0; cmd_fetch = 0; exh_clear = 0;
    rx_enable = 0; pkt_done = 0; upper_addr = 16'h0040; ring_start = 16'h0100;
    ring_end = 16'h0200; ring_wr = 16'h01F1; rp_wr_data = 0; pkt_bytes = 0; eob_words = 0;
    m_rp = 0; m_addr = 0; m_words = 0; m_exh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check_all("R11");
    chk("R11 cmd_pending", 32'(cmd_pending), 0);
    chk("R11 last_pkt", 32'(last_pkt), 0);
    chk("R11 busy/mem_req", 32'({busy, mem_req}), 0);

    // R10 bit 0 dropped on host write
    host_rp(16'h0101);
    chk("R10 host write", 32'(rd_ptr), 32'h0100);

    // R2 R3 R5 narrow fetch
    model_fetch(); pulse_cmd();
    chk("R5 cmd set", 32'(cmd_pending), 1);
    wait_idle();
    check_all("R2 narrow");
    chk("R5 cmd cleared", 32'(cmd_pending), 0);

    // R2 R3 wide fetch
    cfg_wide = 1; @(negedge clk);
    model_fetch(); pulse_cmd(); wait_idle();
    check_all("R3 wide");

    // R3 wrap at end
    host_rp(16'h01F0);
    model_fetch(); pulse_cmd(); wait_idle();
    check_all("R3 wrap");
    chk("R3 wrap value", 32'(rd_ptr), 32'h0100);

    // R4 exhaustion; R10 ignored bit 0 of ring_wr
    ring_wr = 16'h0111; rx_enable = 1; @(negedge clk);
    model_fetch(); pulse_cmd(); wait_idle();
    check_all("R4 exhaust");
    chk("R8 rx_ready low", 32'(rx_ready), 0);
    keep = buf_words[15:0];
    pkt_bytes = 16'd100; pkt_done = 1; @(negedge clk); pkt_done = 0; @(negedge clk);
    chk("R8 refused words", buf_words, m_words);
    chk("R8 refused last", 32'(last_pkt), 0);
    repeat (4) @(negedge clk);
    chk("R4 held", 32'(exhausted), 1);

    // R6 clear with refetch
    ring_wr = 16'h01F0; @(negedge clk);
    m_exh = 0; model_fetch();
    exh_clear = 1; @(negedge clk); exh_clear = 0;
    chk("R6 fetch started", 32'(busy), 1);
    wait_idle();
    check_all("R6 clear");
    chk("R8 rx_ready high", 32'(rx_ready), 1);

    // R6 clear while not exhausted: no effect
    exh_clear = 1; @(negedge clk); exh_clear = 0;
    repeat (3) @(negedge clk);
    chk("R6 no fetch", 32'(busy), 0);
    chk("R6 rd_ptr kept", 32'(rd_ptr), 32'(m_rp));

    // R7 packet accounting and low-space refetch
    cfg_wide = 0; host_rp(16'h0100);
    model_fetch(); pulse_cmd(); wait_idle();
    check_all("R7 setup");
    eob_words = 0; pkt_bytes = 16'd60;
    pkt_done = 1; @(negedge clk); pkt_done = 0;
    m_words = m_words - 32'd32;
    chk("R7 words", buf_words, m_words);
    chk("R7 not last", 32'(last_pkt), 0);
    pkt_bytes = 16'd2;
    nxt = m_words - 32'd3;
    eob_words = nxt[15:0] + 16'd1;
    pkt_done = 1; @(negedge clk); pkt_done = 0;
    chk("R7 words low", buf_words, nxt);
    chk("R7 last set", 32'(last_pkt), 1);
    chk("R7 refetch", 32'(busy), 1);
    model_fetch(); wait_idle();
    check_all("R7 refetch");
    eob_words = 0;

    // R9 request held during a fetch
    model_fetch(); model_fetch();
    pulse_cmd();
    pulse_cmd();
    wait_idle();
    check_all("R9 held");
    chk("R9 cmd cleared", 32'(cmd_pending), 0);

    // random mix
    ring_start = 0; ring_end = 0; ring_wr = 16'hFFFE;
    for (int i = 0; i < 40; i++) begin
      cfg_wide = 1'($urandom);
      upper_addr = 16'($urandom);
      @(negedge clk);
      if (i % 4 == 0) host_rp(16'($urandom) & 16'hFFF0);
      if ($urandom % 2 == 0) begin
        model_fetch(); pulse_cmd(); wait_idle();
        check_all("R2 random fetch");
      end else begin
        pkt_bytes = 16'($urandom % 1500);
        m_words = m_words - ((32'(pkt_bytes) + 32'd4) >> 1);
        pkt_done = 1; @(negedge clk); pkt_done = 0;
        chk("R7 random pkt", buf_words, m_words);
      end
    end
    finish_run();
  end
endmodule